// File: doc/BRIEF.md
# Debug-Port Memory Access Sequencer

This block reads or writes one location in a target microcontroller's memory over a four-wire JTAG port. It also drives a separate target clock line that the target uses to complete each bus cycle. A host issues a single request: a direction, a 16-bit address and, for writes, a 16-bit data word. The block then runs a fixed series of 8-bit instruction shifts and 16-bit data shifts. These select the target's control-signal register, its address register and its data-to-address register in turn. The target clock is pulsed between the shifts to latch the access.

The block decides on its own whether an access is a byte or a word access. Any address at or below a byte-access limit (0x00FF by default) gets a byte access. Any address above the limit gets a word access. Each kind of access uses its own control word. TCK comes from the system clock, with a high phase and a low phase of `TCK_HALF` system cycles each. The four instruction opcodes are parameters.

Top module: `jmas_access_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `tck`, `tms` and `tdi` are 0, `rd_data` is 0x0000 and `tclk` is 1.
- R2: An instruction shift walks Run-Test/Idle to Shift-IR with TMS 1,1,0,0. It then shifts 8 bits MSB first, with TMS high only on the last bit. It returns to Run-Test/Idle with TMS 1,0.
- R3: A data shift walks to Shift-DR with TMS 1,0,0. It then shifts 16 bits MSB first, with TMS high only on the last bit, and leaves with TMS 1,0. The bits sampled from `tdo` on each shifting rising edge are collected MSB first.
- R4: Each TCK high phase lasts exactly `TCK_HALF` system cycles. TMS and TDI change only while TCK is low.
- R5: Every access starts by driving `tclk` low, which has no visible effect if it is already low. It then shifts the control-signal opcode into the instruction register.
- R6: On a read, the control word is 0x2409 when the address is above 0x00FF and 0x2419 otherwise.
- R7: On a write, the control word is 0x2408 when the address is above 0x00FF and 0x2418 otherwise.
- R8: After the control word, the block selects the address opcode and shifts in the address. It then selects the data-to-address opcode.
- R9: A write then shifts in the data word, raises `tclk` and completes. `tclk` is left high.
- R10: A read raises `tclk`, lowers it, then shifts in 0x0000. The 16 bits captured in that shift appear on `rd_data` in the `done` cycle, and `tclk` is left low. `rd_data` keeps its value across writes.
- R11: `busy` is high from the cycle after a request is accepted until `done`. `done` is a single-cycle pulse, and `busy` is already low in that cycle.
- R12: A request that arrives while `busy` is high is dropped. It causes no shift and no later access.
- R13: `tclk` changes only between shifts, while the TAP is in Run-Test/Idle and TCK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Target address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Result of the last read |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to target |
| tdo | input | 1 | JTAG data from target |
| tclk | output | 1 | Target clock line |

## Verification
The bench models the target TAP on the pin level and logs every instruction update, data update and target-clock edge. That log is compared with a sequence built from the requirements. Reads and writes are tried at the byte/word boundary (0x00FF and 0x0100), at zero and at the top of the address space. This separates the four control words and shows any off-by-one error in the address comparison. Read captures with alternating end bits (0x8001, 0x7FFE) expose bit-order and shift-count errors. Back-to-back reads, and a write after a read, show whether the opening low drive of `tclk` is visible. A request injected mid-access shows whether busy requests are truly dropped.

// File: rtl/jmas_pkg.sv
package jmas_pkg;

    localparam int IR_BITS = 8;
    localparam int DR_BITS = 16;
    localparam int IR_HDR  = 4;
    localparam int DR_HDR  = 3;
    localparam int TAIL    = 2;
    localparam int CYC_MAX = DR_HDR + DR_BITS + TAIL - 1;
    localparam int CYC_W   = $clog2(CYC_MAX + 1);
    localparam int IDX_W   = $clog2(DR_BITS);

    localparam logic [DR_BITS-1:0] CW_BASE = 16'h2408;
    localparam int CW_BYTE_BIT = 4;
    localparam int CW_READ_BIT = 0;

    typedef struct packed {
        logic tms;
        logic tdi;
        logic bit_slot;
    } pin_t;

    typedef enum logic [2:0] {
        K_TCLK_LO,
        K_TCLK_HI,
        K_IR,
        K_DR,
        K_END
    } step_kind_e;

    typedef struct packed {
        step_kind_e         kind;
        logic [DR_BITS-1:0] val;
    } step_t;

    typedef struct packed {
        logic               wr;
        logic [DR_BITS-1:0] addr;
        logic [DR_BITS-1:0] wdata;
    } req_t;

    function automatic pin_t shift_pins(input logic ir, input logic [CYC_W-1:0] k,
                                        input logic [DR_BITS-1:0] data);
        pin_t p;
        int kk, hdr, len, j;
        logic [IDX_W-1:0] idx;
        p   = '0;
        kk  = int'(k);
        hdr = ir ? IR_HDR : DR_HDR;
        len = ir ? IR_BITS : DR_BITS;
        if (kk < hdr) begin
            p.tms = (kk == 0) || (ir && kk == 1);
        end else if (kk < hdr + len) begin
            j          = kk - hdr;
            idx        = IDX_W'(len - 1 - j);
            p.tdi      = data[idx];
            p.tms      = (j == len - 1);
            p.bit_slot = 1'b1;
        end else if (kk == hdr + len) begin
            p.tms = 1'b1;
        end
        return p;
    endfunction

    function automatic logic [CYC_W-1:0] last_cycle(input logic ir);
        return ir ? CYC_W'(IR_HDR + IR_BITS + TAIL - 1) : CYC_W'(DR_HDR + DR_BITS + TAIL - 1);
    endfunction

    function automatic logic [DR_BITS-1:0] ctrl_word(input logic wr, input logic byte_sel);
        logic [DR_BITS-1:0] w;
        w              = CW_BASE;
        w[CW_BYTE_BIT] = byte_sel;
        w[CW_READ_BIT] = ~wr;
        return w;
    endfunction

endpackage

// File: rtl/jmas_phase_timer.sv
module jmas_phase_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)        cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);

    p_cnt_restart_r4: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/jmas_shift_engine.sv
module jmas_shift_engine
    import jmas_pkg::*;
#(
    parameter int TCK_HALF = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               is_ir,
    input  logic [DR_BITS-1:0] din,
    input  logic               tdo,
    output logic               busy,
    output logic               done,
    output logic [DR_BITS-1:0] dout,
    output logic               tck,
    output logic               tms,
    output logic               tdi
);
    typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH} eng_state_e;

    eng_state_e         st_q;
    logic [CYC_W-1:0]   k_q;
    logic               ir_q;
    logic [DR_BITS-1:0] data_q, dout_q;
    logic               tck_q, tms_q, tdi_q, done_q;
    logic               tick, run_w;
    pin_t               cur_pins, nxt_pins, first_pins;

    assign run_w = (st_q != E_IDLE);

    jmas_phase_timer #(.HALF(TCK_HALF)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .run  (run_w),
        .tick (tick)
    );

    always_comb begin
        cur_pins   = shift_pins(ir_q, k_q, data_q);
        nxt_pins   = shift_pins(ir_q, CYC_W'(k_q + 1'b1), data_q);
        first_pins = shift_pins(is_ir, '0, din);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= E_IDLE;
            k_q    <= '0;
            ir_q   <= 1'b0;
            data_q <= '0;
            dout_q <= '0;
            tck_q  <= 1'b0;
            tms_q  <= 1'b0;
            tdi_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                E_IDLE: if (start) begin
                    ir_q   <= is_ir;
                    data_q <= din;
                    dout_q <= '0;
                    k_q    <= '0;
                    tms_q  <= first_pins.tms;
                    tdi_q  <= first_pins.tdi;
                    st_q   <= E_LOW;
                end
                E_LOW: if (tick) begin
                    tck_q <= 1'b1;
                    if (cur_pins.bit_slot) dout_q <= {dout_q[DR_BITS-2:0], tdo};
                    st_q  <= E_HIGH;
                end
                E_HIGH: if (tick) begin
                    tck_q <= 1'b0;
                    if (k_q == last_cycle(ir_q)) begin
                        done_q <= 1'b1;
                        st_q   <= E_IDLE;
                    end else begin
                        k_q   <= CYC_W'(k_q + 1'b1);
                        tms_q <= nxt_pins.tms;
                        tdi_q <= nxt_pins.tdi;
                        st_q  <= E_LOW;
                    end
                end
                default: st_q <= E_IDLE;
            endcase
        end
    end

    assign busy = run_w;
    assign done = done_q;
    assign dout = dout_q;
    assign tck  = tck_q;
    assign tms  = tms_q;
    assign tdi  = tdi_q;

    p_pins_move_low_r4: assert property (@(posedge clk) disable iff (rst)
        (!$stable(tms_q) || !$stable(tdi_q)) |-> !tck_q);
    p_done_tck_low_r3: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !tck_q && !tms_q);
    p_start_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
        start |-> !run_w);
endmodule

// File: rtl/jmas_step_decode.sv
module jmas_step_decode
    import jmas_pkg::*;
#(
    parameter logic [DR_BITS-1:0] BYTE_LIMIT = 16'h00FF,
    parameter logic [IR_BITS-1:0] OP_CTRL    = 8'h13,
    parameter logic [IR_BITS-1:0] OP_ADDR    = 8'h83,
    parameter logic [IR_BITS-1:0] OP_D2A     = 8'h85
) (
    input  logic               is_write,
    input  logic [3:0]         idx,
    input  logic [DR_BITS-1:0] addr,
    input  logic [DR_BITS-1:0] wdata,
    output step_t              step
);
    localparam int PAD = DR_BITS - IR_BITS;

    logic byte_sel;
    assign byte_sel = (addr <= BYTE_LIMIT);

    always_comb begin
        step.kind = K_END;
        step.val  = '0;
        case (idx)
            4'd0: step.kind = K_TCLK_LO;
            4'd1: begin step.kind = K_IR; step.val = {{PAD{1'b0}}, OP_CTRL}; end
            4'd2: begin step.kind = K_DR; step.val = ctrl_word(is_write, byte_sel); end
            4'd3: begin step.kind = K_IR; step.val = {{PAD{1'b0}}, OP_ADDR}; end
            4'd4: begin step.kind = K_DR; step.val = addr; end
            4'd5: begin step.kind = K_IR; step.val = {{PAD{1'b0}}, OP_D2A}; end
            4'd6: begin
                if (is_write) begin step.kind = K_DR; step.val = wdata; end
                else          step.kind = K_TCLK_HI;
            end
            4'd7: step.kind = is_write ? K_TCLK_HI : K_TCLK_LO;
            4'd8: begin
                if (!is_write) begin step.kind = K_DR; step.val = '0; end
            end
            default: step.kind = K_END;
        endcase
    end
endmodule

// File: rtl/jmas_access_seq.sv
module jmas_access_seq
    import jmas_pkg::*;
#(
    parameter int                 TCK_HALF   = 2,
    parameter logic [DR_BITS-1:0] BYTE_LIMIT = 16'h00FF,
    parameter logic [IR_BITS-1:0] OP_CTRL    = 8'h13,
    parameter logic [IR_BITS-1:0] OP_ADDR    = 8'h83,
    parameter logic [IR_BITS-1:0] OP_D2A     = 8'h85
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        tck,
    output logic        tms,
    output logic        tdi,
    input  logic        tdo,
    output logic        tclk
);
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_e;

    seq_state_e         st_q;
    req_t               req_q;
    logic [3:0]         idx_q;
    logic [DR_BITS-1:0] last_dr_q, rd_q;
    logic               tclk_q, done_q;
    step_t              cur;
    logic               eng_start, eng_done, eng_busy, eng_is_ir;
    logic [DR_BITS-1:0] eng_dout;

    jmas_step_decode #(
        .BYTE_LIMIT (BYTE_LIMIT),
        .OP_CTRL    (OP_CTRL),
        .OP_ADDR    (OP_ADDR),
        .OP_D2A     (OP_D2A)
    ) u_dec (
        .is_write (req_q.wr),
        .idx      (idx_q),
        .addr     (req_q.addr),
        .wdata    (req_q.wdata),
        .step     (cur)
    );

    assign eng_start = (st_q == S_ISSUE) && (cur.kind == K_IR || cur.kind == K_DR);
    assign eng_is_ir = (cur.kind == K_IR);

    jmas_shift_engine #(.TCK_HALF(TCK_HALF)) u_eng (
        .clk   (clk),
        .rst   (rst),
        .start (eng_start),
        .is_ir (eng_is_ir),
        .din   (cur.val),
        .tdo   (tdo),
        .busy  (eng_busy),
        .done  (eng_done),
        .dout  (eng_dout),
        .tck   (tck),
        .tms   (tms),
        .tdi   (tdi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            req_q     <= '0;
            idx_q     <= '0;
            last_dr_q <= '0;
            rd_q      <= '0;
            tclk_q    <= 1'b1;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                S_IDLE: if (req_valid) begin
                    req_q.wr    <= req_write;
                    req_q.addr  <= req_addr;
                    req_q.wdata <= req_wdata;
                    idx_q       <= '0;
                    st_q        <= S_ISSUE;
                end
                S_ISSUE: begin
                    case (cur.kind)
                        K_TCLK_LO: begin tclk_q <= 1'b0; idx_q <= idx_q + 1'b1; end
                        K_TCLK_HI: begin tclk_q <= 1'b1; idx_q <= idx_q + 1'b1; end
                        K_IR, K_DR: st_q <= S_WAIT;
                        default: begin
                            done_q <= 1'b1;
                            st_q   <= S_IDLE;
                            if (!req_q.wr) rd_q <= last_dr_q;
                        end
                    endcase
                end
                S_WAIT: if (eng_done) begin
                    if (cur.kind == K_DR) last_dr_q <= eng_dout;
                    idx_q <= idx_q + 1'b1;
                    st_q  <= S_ISSUE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign busy    = (st_q != S_IDLE);
    assign done    = done_q;
    assign rd_data = rd_q;
    assign tclk    = tclk_q;

    p_tclk_between_shifts_r13: assert property (@(posedge clk) disable iff (rst)
        !$stable(tclk_q) |-> !tck && !eng_busy);
    p_busy_from_req_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));
    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    p_done_after_busy_r11: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(busy) && !busy);
    p_busy_req_dropped_r12: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> $stable(req_q.addr) && $stable(req_q.wr));
endmodule

// File: tb/jmas_access_seq_tb_top.sv
module jmas_access_seq_tb_top;
    localparam int HALF = 2;
    localparam logic [7:0] OPC_CTRL = 8'h13;
    localparam logic [7:0] OPC_ADDR = 8'h83;
    localparam logic [7:0] OPC_D2A  = 8'h85;

    localparam int T_TLR = 0, T_RTI = 1, T_SDS = 2, T_CDR = 3, T_SHDR = 4, T_E1DR = 5,
                   T_PDR = 6, T_E2DR = 7, T_UDR = 8, T_SIS = 9, T_CIR = 10, T_SHIR = 11,
                   T_E1IR = 12, T_PIR = 13, T_E2IR = 14, T_UIR = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic busy, done, tck, tms, tdi, tclk;
    logic tdo_b = 1'b0;
    logic [15:0] rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    jmas_access_seq #(.TCK_HALF(HALF), .OP_CTRL(OPC_CTRL), .OP_ADDR(OPC_ADDR), .OP_D2A(OPC_D2A)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo_b), .tclk(tclk)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int tap_next(input int s, input logic t);
        case (s)
            T_TLR:  return t ? T_TLR  : T_RTI;
            T_RTI:  return t ? T_SDS  : T_RTI;
            T_SDS:  return t ? T_SIS  : T_CDR;
            T_CDR:  return t ? T_E1DR : T_SHDR;
            T_SHDR: return t ? T_E1DR : T_SHDR;
            T_E1DR: return t ? T_UDR  : T_PDR;
            T_PDR:  return t ? T_E2DR : T_PDR;
            T_E2DR: return t ? T_UDR  : T_SHDR;
            T_UDR:  return t ? T_SDS  : T_RTI;
            T_SIS:  return t ? T_TLR  : T_CIR;
            T_CIR:  return t ? T_E1IR : T_SHIR;
            T_SHIR: return t ? T_E1IR : T_SHIR;
            T_E1IR: return t ? T_UIR  : T_PIR;
            T_PIR:  return t ? T_E2IR : T_PIR;
            T_E2IR: return t ? T_UIR  : T_SHIR;
            default: return t ? T_SDS : T_RTI;
        endcase
    endfunction

    // Target model: event log {type, value}; type 1 = IR update, 2 = DR update, 3 = tclk edge
    logic [17:0] evq[$];
    logic [17:0] exq[$];
    string       extag[$];
    int          tap = T_RTI;
    logic [15:0] dr_sr = '0;
    logic [7:0]  ir_sr = '0, ir_reg = '0;
    logic [15:0] capval = '0;
    int          bits = 0, hi_run = 0;
    logic        tck_p = 1'b0, tms_p = 1'b0, tdi_p = 1'b0, tclk_p = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            int nxt;
            if (tck && !tck_p) begin
                if (tap == T_SHDR) begin dr_sr = {dr_sr[14:0], tdi}; bits++; end
                else if (tap == T_SHIR) begin ir_sr = {ir_sr[6:0], tdi}; bits++; end
                nxt = tap_next(tap, tms);
                if (nxt == T_CDR) begin dr_sr = (ir_reg == OPC_D2A) ? capval : 16'h5A5A; bits = 0; end
                if (nxt == T_CIR) begin ir_sr = 8'h01; bits = 0; end
                if (nxt == T_UDR) begin
                    evq.push_back({2'd2, dr_sr});
                    check(bits == 16, "R3", "data shift length", bits, 16);
                end
                if (nxt == T_UIR) begin
                    ir_reg = ir_sr;
                    evq.push_back({2'd1, 8'h00, ir_sr});
                    check(bits == 8, "R2", "instruction shift length", bits, 8);
                end
                tap = nxt;
            end
            if (tck) hi_run++;
            if (!tck && tck_p) begin
                check(hi_run == HALF, "R4", "tck high phase", hi_run, HALF);
                hi_run = 0;
                if (tap == T_SHDR) tdo_b <= dr_sr[15];
                else if (tap == T_SHIR) tdo_b <= ir_sr[7];
            end
            if ((tms !== tms_p || tdi !== tdi_p) && tck)
                check(1'b0, "R4", "tms/tdi moved while tck high", {tms, tdi}, {tms_p, tdi_p});
            if (tclk !== tclk_p) begin
                check(tap == T_RTI && !tck, "R13", "tclk edge outside idle", tap, T_RTI);
                evq.push_back({2'd3, 15'h0, tclk});
            end
        end
        tck_p  = tck;
        tms_p  = tms;
        tdi_p  = tdi;
        tclk_p = tclk;
    end

    bit          exp_tclk = 1'b1;
    logic [15:0] exp_rd = 16'h0000;

    task automatic expect_ev(input logic [1:0] ty, input logic [15:0] v, input string tag);
        exq.push_back({ty, v});
        extag.push_back(tag);
    endtask

    task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          input logic [15:0] cap, input bit poke);
        logic [15:0] cw;
        int n;
        if (wr) cw = (a > 16'h00FF) ? 16'h2408 : 16'h2418;
        else    cw = (a > 16'h00FF) ? 16'h2409 : 16'h2419;
        if (exp_tclk) expect_ev(2'd3, 16'h0000, "R5");
        expect_ev(2'd1, {8'h00, OPC_CTRL}, "R5");
        expect_ev(2'd2, cw, wr ? "R7" : "R6");
        expect_ev(2'd1, {8'h00, OPC_ADDR}, "R8");
        expect_ev(2'd2, a, "R8");
        expect_ev(2'd1, {8'h00, OPC_D2A}, "R8");
        if (wr) begin
            expect_ev(2'd2, d, "R9");
            expect_ev(2'd3, 16'h0001, "R9");
            exp_tclk = 1'b1;
        end else begin
            expect_ev(2'd3, 16'h0001, "R10");
            expect_ev(2'd3, 16'h0000, "R10");
            expect_ev(2'd2, 16'h0000, "R10");
            exp_tclk = 1'b0;
            exp_rd = cap;
        end
        capval = cap;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy === 1'b1, "R11", "busy after accept", busy, 1);
        if (poke) begin
            repeat (40) @(negedge clk);
            req_valid = 1'b1; req_write = ~wr; req_addr = 16'h0001; req_wdata = 16'hDEAD;
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (done !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
        check(done === 1'b1, "R11", "done seen", done, 1);
        check(busy === 1'b0, "R11", "busy low with done", busy, 0);
        @(negedge clk);
        check(done === 1'b0, "R11", "done single pulse", done, 0);
        check(rd_data === exp_rd, "R10", "rd_data", rd_data, exp_rd);
        check(tclk === exp_tclk, wr ? "R9" : "R10", "tclk level after access", tclk, exp_tclk);
        check(evq.size() == exq.size(), "R5", "event count", evq.size(), exq.size());
        for (int i = 0; i < exq.size(); i++) begin
            logic [17:0] got;
            got = (i < evq.size()) ? evq[i] : 18'h3FFFF;
            check(got === exq[i], extag[i], "event", got, exq[i]);
        end
        evq.delete();
        exq.delete();
        extag.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset", {busy, done}, 0);
        check(tck === 1'b0 && tms === 1'b0 && tdi === 1'b0, "R1", "jtag pins after reset", {tck, tms, tdi}, 0);
        check(tclk === 1'b1, "R1", "tclk after reset", tclk, 1);
        check(rd_data === 16'h0000, "R1", "rd_data after reset", rd_data, 0);

        access(1'b0, 16'h0200, 16'h0000, 16'hBEEF, 1'b0);
        access(1'b0, 16'h00FF, 16'h0000, 16'h00A5, 1'b0);
        access(1'b1, 16'h0100, 16'h1234, 16'h0000, 1'b0);
        access(1'b1, 16'h0010, 16'hFFFF, 16'h0000, 1'b0);
        access(1'b0, 16'h0000, 16'h0000, 16'h8001, 1'b0);
        access(1'b0, 16'hFFFF, 16'h0000, 16'h7FFE, 1'b1);
        access(1'b1, 16'hFFFE, 16'h0000, 16'h0000, 1'b1);

        repeat (60) @(negedge clk);
        check(busy === 1'b0, "R12", "no access after dropped request", busy, 0);
        check(evq.size() == 0, "R12", "no pin activity after dropped request", evq.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog expired actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule